// File: doc/BRIEF.md
# Per-Channel Fault Filter and Shutdown

This block carries the digital protection and fault classification for one channel of a low-side power switch. It takes the active-low channel command and four comparator flags from the analog side (overcurrent, overtemperature, drain below the ground-short reference, load current below the open-load threshold). It drives the gate enable of the power stage. It also emits a one-cycle store strobe with a 2-bit fault code, which a separate failure register captures.

All five inputs are asynchronous and first pass through two-flop synchronisers. Filter times are counted in cycles of the block clock (nominally a 325 kHz oscillator). A sustained overcurrent or any overtemperature while the stage conducts opens the gate at once and holds it open until the command is withdrawn and given again. A single counter filters both the off-state ground-short check and the on-state open-load check. An open load that clears while the stage is still on is reported as soon as it clears (sporadic). One still present when the command turns the stage off is reported with that command edge (static).

Top module: `chan_guard`

## Requirements
- R1: The command is active low. Two cycles after `ctl_n` is sampled low the gate is commanded, and `gate_en` rises on the third rising clock edge after the change. With `ctl_n` held high (its idle, undriven level) `gate_en` stays 0.
- R2: While the gate is on, `oc_flag` held for at least SCB_CYC clock cycles opens the gate and strobes code 2'b01 on edge SCB_CYC+1 counted from the first sampling edge (edge 0). A shorter overcurrent pulse leaves the gate on and strobes nothing.
- R3: While the gate is on, a one-cycle `ot_flag` pulse opens the gate and strobes code 2'b01 on edge 2.
- R4: After an overcurrent or overtemperature trip the gate stays off while the command stays on, even after the flag clears. Taking the command off and back on turns the gate on again.
- R5: With the gate off, `gnd_flag` held for at least FLT_CYC cycles strobes code 2'b00 on edge FLT_CYC+1. A shorter pulse restarts the filter and strobes nothing.
- R6: With the gate on, an `ol_flag` pulse shorter than FLT_CYC cycles strobes nothing.
- R7: With the gate on, an `ol_flag` pulse of L >= FLT_CYC cycles that ends while the command is still on strobes code 2'b10 on edge L+2 (sporadic open load).
- R8: An open load that has passed the filter and is still present when the command goes off strobes code 2'b10 on edge 2 after the command change (static open load).
- R9: When a trip and an open-load report fall in the same cycle, one strobe carries code 2'b01, and no open-load report follows.
- R10: `store` is a single-cycle strobe per detected fault, and `status` reads 2'b11 whenever `store` is low.
- R11: Synchronous `rst` or `uv` forces `gate_en`, `store` to 0 on the next edge and clears the synchronisers, trip latch and filter. A ground-short condition interrupted by `uv` must then meet the full filter time again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (oscillator) |
| rst | input | 1 | Synchronous active-high reset |
| uv | input | 1 | Supply undervoltage, acts like reset |
| ctl_n | input | 1 | Channel command, low = stage on |
| oc_flag | input | 1 | Overcurrent comparator, asynchronous |
| ot_flag | input | 1 | Overtemperature comparator, asynchronous |
| gnd_flag | input | 1 | Drain below ground-short reference, asynchronous |
| ol_flag | input | 1 | Load current below open-load threshold, asynchronous |
| gate_en | output | 1 | Power stage gate enable |
| store | output | 1 | One-cycle strobe to the failure register |
| status | output | 2 | Fault code valid with `store`, else 2'b11 |

## Verification
A thermal trip and the release of a filtered open-load condition can occur in the same cycle. Both events then compete for the single strobe. The bench lets an open load pass the filter, then drops `ol_flag` and raises `ot_flag` at the same falling edge, so both synchronised flags change together. It expects exactly one strobe, carrying the short-to-battery code on edge 2, and no open-load strobe in the cycles after the gate opens.

// File: rtl/chan_guard_pkg.sv
package chan_guard_pkg;

    // Codes seen by the failure register
    typedef enum logic [1:0] {
        FC_GND  = 2'b00,
        FC_BATT = 2'b01,
        FC_OPEN = 2'b10,
        FC_NONE = 2'b11
    } fault_code_e;

    // Raw and synchronised sense inputs, command in the top bit
    typedef struct packed {
        logic ctl_n;
        logic oc;
        logic ot;
        logic gnd;
        logic ol;
    } sense_t;

    localparam int SENSE_W = $bits(sense_t);

    // Idle level: command off, no flags raised
    localparam logic [SENSE_W-1:0] SENSE_IDLE = 5'b10000;

    // Short to battery outranks ground short, which outranks open load
    function automatic fault_code_e pick_code(input logic trip, input logic gnd, input logic ol);
        if (trip)     return FC_BATT;
        else if (gnd) return FC_GND;
        else if (ol)  return FC_OPEN;
        else          return FC_NONE;
    endfunction

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (clr) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cg_trip.sv
module cg_trip #(
    parameter int SCB_CYC = 5
) (
    input  logic clk,
    input  logic clr,
    input  logic on_req,
    input  logic oc,
    input  logic ot,
    output logic gate_q,
    output logic trip_set
);
    localparam int CW = $clog2(SCB_CYC + 1);

    logic [CW-1:0] oc_cnt;
    logic          trip_q;
    logic          oc_live;

    assign oc_live  = gate_q && oc;
    assign trip_set = gate_q && (ot || (oc && oc_cnt == CW'(SCB_CYC - 1)));

    always_ff @(posedge clk) begin
        if (clr) begin
            oc_cnt <= '0;
            trip_q <= 1'b0;
            gate_q <= 1'b0;
        end else begin
            if (!oc_live)
                oc_cnt <= '0;
            else if (oc_cnt != CW'(SCB_CYC))
                oc_cnt <= oc_cnt + 1'b1;
            // latch holds until the command is withdrawn
            trip_q <= trip_set || (trip_q && on_req);
            gate_q <= on_req && !trip_set && !trip_q;
        end
    end
endmodule

// File: rtl/cg_diag.sv
module cg_diag #(
    parameter int FLT_CYC = 55
) (
    input  logic clk,
    input  logic clr,
    input  logic gate_q,
    input  logic on_req,
    input  logic gnd,
    input  logic ol,
    output logic gnd_evt,
    output logic ol_evt
);
    localparam int CW = $clog2(FLT_CYC + 1);

    logic [CW-1:0] flt_cnt;
    logic          gate_d;
    logic          cond;
    logic          restart;
    logic          fire;
    logic          ol_seen;

    // one counter: drain check while off, load check while on
    assign cond    = gate_q ? ol : gnd;
    assign restart = (gate_q != gate_d) || !cond;
    assign fire    = !restart && flt_cnt == CW'(FLT_CYC - 1);

    assign gnd_evt = fire && !gate_q;
    // sporadic: condition cleared while on; static: command withdrawn
    assign ol_evt  = ol_seen && gate_q && (!ol || !on_req);

    always_ff @(posedge clk) begin
        if (clr) begin
            flt_cnt <= '0;
            gate_d  <= 1'b0;
            ol_seen <= 1'b0;
        end else begin
            gate_d <= gate_q;
            if (restart)
                flt_cnt <= '0;
            else if (flt_cnt != CW'(FLT_CYC))
                flt_cnt <= flt_cnt + 1'b1;
            if (!gate_q || ol_evt)
                ol_seen <= 1'b0;
            else if (fire)
                ol_seen <= 1'b1;
        end
    end
endmodule

// File: rtl/chan_guard.sv
module chan_guard
    import chan_guard_pkg::*;
#(
    parameter int SCB_CYC = 5,
    parameter int FLT_CYC = 55
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       uv,
    input  logic       ctl_n,
    input  logic       oc_flag,
    input  logic       ot_flag,
    input  logic       gnd_flag,
    input  logic       ol_flag,
    output logic       gate_en,
    output logic       store,
    output logic [1:0] status
);
    sense_t              raw;
    sense_t              syn;
    logic [SENSE_W-1:0]  syn_bits;
    logic                clr;
    logic                on_req;
    logic                gate_q;
    logic                trip_set;
    logic                gnd_evt;
    logic                ol_evt;
    fault_code_e         code_q;
    logic                store_q;

    assign clr = rst || uv;
    assign raw = {ctl_n, oc_flag, ot_flag, gnd_flag, ol_flag};

    cg_sync #(
        .W       (SENSE_W),
        .RST_VAL (SENSE_IDLE)
    ) u_sync (
        .clk (clk),
        .clr (clr),
        .d   (raw),
        .q   (syn_bits)
    );

    assign syn    = sense_t'(syn_bits);
    assign on_req = !syn.ctl_n;

    cg_trip #(
        .SCB_CYC (SCB_CYC)
    ) u_trip (
        .clk      (clk),
        .clr      (clr),
        .on_req   (on_req),
        .oc       (syn.oc),
        .ot       (syn.ot),
        .gate_q   (gate_q),
        .trip_set (trip_set)
    );

    cg_diag #(
        .FLT_CYC (FLT_CYC)
    ) u_diag (
        .clk     (clk),
        .clr     (clr),
        .gate_q  (gate_q),
        .on_req  (on_req),
        .gnd     (syn.gnd),
        .ol      (syn.ol),
        .gnd_evt (gnd_evt),
        .ol_evt  (ol_evt)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            store_q <= 1'b0;
            code_q  <= FC_NONE;
        end else begin
            store_q <= trip_set || gnd_evt || ol_evt;
            code_q  <= pick_code(trip_set, gnd_evt, ol_evt);
        end
    end

    assign gate_en = gate_q;
    assign store   = store_q;
    assign status  = code_q;
endmodule

// File: rtl/chan_guard_chk.sv
module chan_guard_chk
    import chan_guard_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       uv,
    input logic       on_req,
    input logic       gate_en,
    input logic       store,
    input logic [1:0] status
);
    // R11: reset or undervoltage clears the outputs on the next edge
    assert_clear_R11: assert property (@(posedge clk)
        (rst || uv) |=> (!gate_en && !store));

    // R1: no gate without a synchronised command
    assert_cmd_gate_R1: assert property (@(posedge clk) disable iff (rst || uv)
        !on_req |=> !gate_en);

    // R4: an open gate under a steady command stays open
    assert_latch_R4: assert property (@(posedge clk) disable iff (rst || uv)
        (on_req && $past(on_req) && !gate_en) |=> !gate_en);

    // R10: idle code when no strobe, real code with it
    assert_idle_code_R10: assert property (@(posedge clk) disable iff (rst || uv)
        !store |-> status == FC_NONE);
    assert_strobe_code_R10: assert property (@(posedge clk) disable iff (rst || uv)
        store |-> status != FC_NONE);

    // R5: ground short only reported from the off state
    assert_gnd_off_R5: assert property (@(posedge clk) disable iff (rst || uv)
        (store && status == FC_GND) |-> !$past(gate_en));

    // R7: open load only reported from the on state
    assert_open_on_R7: assert property (@(posedge clk) disable iff (rst || uv)
        (store && status == FC_OPEN) |-> $past(gate_en));

    // R2: a trip report comes with the gate already open
    assert_trip_off_R2: assert property (@(posedge clk) disable iff (rst || uv)
        (store && status == FC_BATT) |-> !gate_en);
endmodule

bind chan_guard chan_guard_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .uv      (uv),
    .on_req  (on_req),
    .gate_en (gate_en),
    .store   (store),
    .status  (status)
);

// File: tb/chan_guard_bench.sv
`timescale 1ns/1ps
module chan_guard_bench;
    localparam int SCB = 5;
    localparam int FLT = 55;
    localparam real HALF = 4.0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       uv = 1'b0;
    logic       ctl_n = 1'b1;
    logic       oc_flag = 1'b0;
    logic       ot_flag = 1'b0;
    logic       gnd_flag = 1'b0;
    logic       ol_flag = 1'b0;
    logic       gate_en;
    logic       store;
    logic [1:0] status;

    int checks = 0;
    int errors = 0;

    always #(HALF) clk = ~clk;

    chan_guard #(.SCB_CYC(SCB), .FLT_CYC(FLT)) u_chan_guard (
        .clk(clk), .rst(rst), .uv(uv), .ctl_n(ctl_n),
        .oc_flag(oc_flag), .ot_flag(ot_flag), .gnd_flag(gnd_flag), .ol_flag(ol_flag),
        .gate_en(gate_en), .store(store), .status(status)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_sig(input int which, input logic v);
        case (which)
            0: oc_flag  = v;
            1: ot_flag  = v;
            2: gnd_flag = v;
            3: ol_flag  = v;
            default: ;
        endcase
    endtask

    // drive one flag for len edges, watch total edges; index 0 = first edge
    task automatic pulse(input int which, input int len, input int total,
                         output int idx, output int code, output int nstore, output int idle_bad);
        idx = -1; code = 3; nstore = 0; idle_bad = 0;
        set_sig(which, 1'b1);
        for (int i = 0; i < total; i++) begin
            tick();
            if (store) begin
                nstore++;
                if (idx < 0) begin idx = i; code = int'(status); end
            end else if (status != 2'b11) idle_bad++;
            if (i == len - 1) set_sig(which, 1'b0);
        end
    endtask

    // filtered event fires on edge thr+1 if the pulse is long enough
    function automatic int exp_filtered(input int len, input int thr);
        return (len >= thr) ? thr + 1 : -1;
    endfunction

    // sporadic open load reports two edges after the pulse ends
    function automatic int exp_sporadic(input int len);
        return (len >= FLT) ? len + 2 : -1;
    endfunction

    task automatic rearm();
        ctl_n = 1'b1;
        repeat (4) tick();
        ctl_n = 1'b0;
        repeat (4) tick();
    endtask

    initial begin
        #(HALF * 2 * 150000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int idx, code, ns, ib, len, n;
        void'($urandom(32'd2718));

        @(negedge clk);
        repeat (5) tick();
        chk("R11 reset gate", int'(gate_en), 0);
        chk("R11 reset store", int'(store), 0);
        chk("R10 reset status", int'(status), 3);
        rst = 1'b0;
        repeat (5) tick();
        chk("R1 idle command keeps gate off", int'(gate_en), 0);

        // ground short while off
        pulse(2, FLT, FLT + 6, idx, code, ns, ib);
        chk("R5 gnd exact edge", idx, FLT + 1);
        chk("R5 gnd code", code, 0);
        chk("R10 single strobe", ns, 1);
        chk("R10 idle status", ib, 0);
        repeat (4) tick();
        pulse(2, FLT - 1, FLT + 6, idx, code, ns, ib);
        chk("R5 short gnd ignored", idx, -1);
        repeat (4) tick();
        for (int k = 0; k < 8; k++) begin
            len = FLT - 3 + int'($urandom_range(6));
            pulse(2, len, len + 6, idx, code, ns, ib);
            chk("R5 random gnd edge", idx, exp_filtered(len, FLT));
            chk("R10 random gnd strobes", ns, (len >= FLT) ? 1 : 0);
            repeat (4) tick();
        end

        // turn on
        ctl_n = 1'b0;
        n = -1;
        for (int i = 0; i < 6; i++) begin
            tick();
            if (gate_en && n < 0) n = i;
        end
        chk("R1 turn-on edge", n, 2);

        // open load while on
        pulse(3, FLT - 1, FLT + 6, idx, code, ns, ib);
        chk("R6 short open load ignored", idx, -1);
        repeat (4) tick();
        pulse(3, FLT + 4, FLT + 12, idx, code, ns, ib);
        chk("R7 sporadic edge", idx, FLT + 6);
        chk("R7 sporadic code", code, 2);
        repeat (4) tick();
        for (int k = 0; k < 6; k++) begin
            len = FLT - 3 + int'($urandom_range(6));
            pulse(3, len, len + 6, idx, code, ns, ib);
            chk("R7 random sporadic edge", idx, exp_sporadic(len));
            chk("R6 random gate stays on", int'(gate_en), 1);
            repeat (4) tick();
        end

        // overcurrent
        pulse(0, SCB - 1, SCB + 6, idx, code, ns, ib);
        chk("R2 short overcurrent ignored", idx, -1);
        chk("R2 gate still on", int'(gate_en), 1);
        pulse(0, SCB, SCB + 6, idx, code, ns, ib);
        chk("R2 trip edge", idx, SCB + 1);
        chk("R2 trip code", code, 1);
        repeat (10) tick();
        chk("R4 latched off", int'(gate_en), 0);
        rearm();
        chk("R4 rearm on", int'(gate_en), 1);
        for (int k = 0; k < 6; k++) begin
            len = SCB - 2 + int'($urandom_range(4));
            pulse(0, len, len + 6, idx, code, ns, ib);
            chk("R2 random trip edge", idx, exp_filtered(len, SCB));
            chk("R4 random gate state", int'(gate_en), (len >= SCB) ? 0 : 1);
            rearm();
        end

        // overtemperature
        pulse(1, 1, 6, idx, code, ns, ib);
        chk("R3 thermal edge", idx, 2);
        chk("R3 thermal code", code, 1);
        rearm();

        // static open load
        pulse(3, FLT + 5, FLT + 5, idx, code, ns, ib);
        chk("R8 nothing while present", idx, -1);
        ol_flag = 1'b1;
        ctl_n = 1'b1;
        pulse(4, 0, 6, idx, code, ns, ib);
        chk("R8 static edge", idx, 2);
        chk("R8 static code", code, 2);
        ol_flag = 1'b0;
        ctl_n = 1'b0;
        repeat (4) tick();

        // thermal trip and open-load release in one cycle
        pulse(3, FLT + 5, FLT + 5, idx, code, ns, ib);
        ol_flag = 1'b1;
        pulse(4, 0, 0, idx, code, ns, ib);
        ol_flag = 1'b0;
        ot_flag = 1'b1;
        pulse(4, 0, 10, idx, code, ns, ib);
        chk("R9 collision edge", idx, 2);
        chk("R9 collision code", code, 1);
        chk("R9 single strobe", ns, 1);
        ot_flag = 1'b0;
        rearm();

        // undervoltage
        uv = 1'b1;
        tick();
        chk("R11 uv gate off", int'(gate_en), 0);
        uv = 1'b0;
        repeat (4) tick();
        chk("R11 gate back after uv", int'(gate_en), 1);
        ctl_n = 1'b1;
        repeat (4) tick();
        pulse(4, 0, 0, idx, code, ns, ib);
        gnd_flag = 1'b1;
        pulse(4, 0, 40, idx, code, ns, ib);
        n = ns;
        uv = 1'b1;
        tick();
        uv = 1'b0;
        pulse(4, 0, 40, idx, code, ns, ib);
        chk("R11 filter restarted by uv", n + ns, 0);
        gnd_flag = 1'b0;
        repeat (4) tick();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule